// File: doc/BRIEF.md
# SDIO Vendor Sleep-Control Register Bank

This block is the device-side set of vendor registers in the reserved upper range of the SDIO function-0 common register space. A simple register port carries single-byte accesses: an address, write data, a write strobe and combinational read data. The SD bus framing, CRC and the actual power gating sit outside the block and appear here only as plain ports.

The main register holds a deep-sleep state. The two low bits encode three modes. In torpid the chip may sleep. In awake the chip must stay out of sleep. Drowsy means awake plus an interrupt toward the host once the chip reports that it is awake. The power manager reads the `sleepAllowed` output and reports back on `isAwake`.

The other registers are:
- an interrupt register that the host clears by writing a one;
- two scratch bytes that the host writes;
- two scratch bytes that the chip loads and the host can only read;
- a standard I/O-enable byte and an extended I/O-enable byte. A function whose standard bit is set while its extended bit is clear has gone through an internal reset.

Top module: `vendor_sleep_bank`

## Requirements
- R1: After reset every register reads 0x00, `sleepAllowed` is 1 (torpid), and `hostIrq`, `ioActive`, `resetFlag` and `hostScratch` are all zero.
- R2: Address 0xF0 holds the sleep state. Bits 7:4 are the function number, driven on `sleepFunc`. Bit 1 is the ready-interrupt enable and bit 0 is the wake request. Reads return bits 7:4, 1 and 0, with bits 3:2 reading as zero.
- R3: `sleepAllowed` is 1 exactly when bit 0 of the sleep state is 0. Writing 0x00 permits sleep and writing 0x01 forbids it.
- R4: A write to 0xF0 with bits 1:0 = 11 (drowsy) arms the ready event. On the first clock edge after that write at which `isAwake` is 1, the ready pending bit is set, one cycle later. Each such write fires the event at most once. A later write with any other encoding disarms it.
- R5: Address 0xF1 reads {000000, readyPending, funcPending}. A write with bit 0 = 1 clears both pending bits, and a write with bit 0 = 0 changes nothing. `hostIrq` is the OR of the two pending bits.
- R6: A one-cycle pulse on `funcIrqSet` sets funcPending.
- R7: When a set event (`funcIrqSet` or a ready event) and a clear write fall on the same edge, the set wins.
- R8: Addresses 0xF2 and 0xF3 are host read/write scratch bytes. They drive `hostScratch`, with 0xF2 in the low byte.
- R9: Addresses 0xF4 and 0xF5 load from `chipScrData` when `chipScrWe` bit 0 or bit 1 is high, respectively. Host writes to these addresses are ignored.
- R10: The standard I/O enable is at 0x02 and the extended I/O enable is at 0xF6; both are host read/write. `resetFlag` = standard AND NOT extended, and `ioActive` = standard AND extended.
- R11: A `funcReset` bit clears the matching extended-enable bit. On the same edge it overrides a host write of that bit.
- R12: Reads of 0xF7 through 0xFF, and of any other address not listed here, return 0x00. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 8 | Write data |
| regWrite | input | 1 | Write strobe |
| regRdata | output | 8 | Read data for regAddr |
| isAwake | input | 1 | Power manager reports chip awake |
| sleepAllowed | output | 1 | Deep sleep permitted |
| sleepFunc | output | 4 | Function number from sleep register |
| funcIrqSet | input | 1 | Generic function raises interrupt |
| hostIrq | output | 1 | Pending interrupt toward host |
| chipScrWe | input | 2 | Chip-side load strobe per scratch byte |
| chipScrData | input | 8 | Chip-side scratch load data |
| hostScratch | output | 16 | Host-written scratch bytes |
| funcReset | input | 8 | Internal per-function reset |
| resetFlag | output | 8 | Functions flagged as internally reset |
| ioActive | output | 8 | Functions enabled in both registers |

## Verification
Two pairs of events can land on the same edge.

The first pair is a set event and a host write-one-to-clear to 0xF1. The bench provokes it twice: once by pulsing `funcIrqSet` in the same cycle as the clear write, and once by raising `isAwake` while drowsy is armed in the cycle of the clear. In both cases it judges the result from `hostIrq` and the 0xF1 readback, expecting the pending bit to survive.

The second pair is a `funcReset` pulse on the same edge as a host write to 0xF6. The readback of 0xF6 must show the reset bit cleared while the other written bits stay set.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 8;
  localparam int unsigned SCR_N  = 2;
  localparam int unsigned SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  localparam logic [AW-1:0] ADR_STDEN = 8'h02;
  localparam logic [AW-1:0] ADR_SLEEP = 8'hF0;
  localparam logic [AW-1:0] ADR_IRQ   = 8'hF1;
  localparam logic [AW-1:0] ADR_HSCR  = 8'hF2;
  localparam logic [AW-1:0] ADR_CSCR  = ADR_HSCR + AW'(SCR_N);
  localparam logic [AW-1:0] ADR_EXTEN = ADR_CSCR + AW'(SCR_N);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SLEEP, SEL_IRQ, SEL_HSCR, SEL_CSCR, SEL_EXTEN, SEL_STDEN
  } rdSel_t;

  typedef enum logic [1:0] {
    MODE_TORPID, MODE_AWAKE, MODE_DROWSY, MODE_ENONLY
  } sleepMode_t;

  typedef struct packed {
    logic              wrSleep;
    logic              wrIrqClr;
    logic [SCR_N-1:0]  wrHostScr;
    logic              wrStdEn;
    logic              wrExtEn;
    logic              setReady;
    rdSel_t            rdSel;
    logic [SCR_IW-1:0] scrIdx;
  } vsbStrobe_t;

  function automatic sleepMode_t decodeMode(input logic [1:0] bits);
    case (bits)
      2'b00:   return MODE_TORPID;
      2'b01:   return MODE_AWAKE;
      2'b11:   return MODE_DROWSY;
      default: return MODE_ENONLY;
    endcase
  endfunction
endpackage

// File: rtl/vsb_ctrl.sv
module vsb_ctrl
  import vsb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic [1:0]    wrLow,
  input  logic          regWrite,
  input  logic          isAwake,
  output vsbStrobe_t    stb
);
  logic          armed;
  logic [AW-1:0] hOff;
  logic [AW-1:0] cOff;
  logic          inHost;
  logic          inChip;

  assign hOff   = regAddr - ADR_HSCR;
  assign cOff   = regAddr - ADR_CSCR;
  assign inHost = (regAddr >= ADR_HSCR) && (regAddr < ADR_CSCR);
  assign inChip = (regAddr >= ADR_CSCR) && (regAddr < ADR_EXTEN);

  always_comb begin
    stb          = '0;
    stb.rdSel    = SEL_NONE;
    stb.setReady = armed & isAwake;
    if (regAddr == ADR_SLEEP) begin
      stb.rdSel   = SEL_SLEEP;
      stb.wrSleep = regWrite;
    end else if (regAddr == ADR_IRQ) begin
      stb.rdSel    = SEL_IRQ;
      stb.wrIrqClr = regWrite & wrLow[0];
    end else if (inHost) begin
      stb.rdSel  = SEL_HSCR;
      stb.scrIdx = hOff[SCR_IW-1:0];
      stb.wrHostScr[hOff[SCR_IW-1:0]] = regWrite;
    end else if (inChip) begin
      stb.rdSel  = SEL_CSCR;
      stb.scrIdx = cOff[SCR_IW-1:0];
    end else if (regAddr == ADR_EXTEN) begin
      stb.rdSel   = SEL_EXTEN;
      stb.wrExtEn = regWrite;
    end else if (regAddr == ADR_STDEN) begin
      stb.rdSel   = SEL_STDEN;
      stb.wrStdEn = regWrite;
    end
  end

  // Arm on a drowsy write; fire once when the chip is awake.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (stb.wrSleep) begin
      armed <= (decodeMode(wrLow) == MODE_DROWSY);
    end else if (stb.setReady) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/vsb_data.sv
module vsb_data
  import vsb_pkg::*;
#(
  parameter int unsigned FUNC_N = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  vsbStrobe_t          stb,
  input  logic [DW-1:0]       regWdata,
  output logic [DW-1:0]       regRdata,
  output logic                sleepAllowed,
  output logic [3:0]          sleepFunc,
  input  logic                funcIrqSet,
  output logic                hostIrq,
  input  logic [SCR_N-1:0]    chipScrWe,
  input  logic [DW-1:0]       chipScrData,
  output logic [SCR_N*DW-1:0] hostScratch,
  input  logic [FUNC_N-1:0]   funcReset,
  output logic [FUNC_N-1:0]   resetFlag,
  output logic [FUNC_N-1:0]   ioActive
);
  logic [3:0]        funcQ;
  logic              wakeReqQ;
  logic              rdyEnQ;
  logic              readyPend;
  logic              funcPend;
  logic [DW-1:0]     hostScr [SCR_N];
  logic [DW-1:0]     chipScr [SCR_N];
  logic [FUNC_N-1:0] stdEn;
  logic [FUNC_N-1:0] extEn;
  logic [DW-1:0]     stdPad;
  logic [DW-1:0]     extPad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcQ    <= '0;
      wakeReqQ <= 1'b0;
      rdyEnQ   <= 1'b0;
    end else if (stb.wrSleep) begin
      funcQ    <= regWdata[7:4];
      rdyEnQ   <= regWdata[1];
      wakeReqQ <= regWdata[0];
    end
  end

  // Set has priority over the write-one-to-clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyPend <= 1'b0;
      funcPend  <= 1'b0;
    end else begin
      if (stb.setReady)      readyPend <= 1'b1;
      else if (stb.wrIrqClr) readyPend <= 1'b0;
      if (funcIrqSet)        funcPend  <= 1'b1;
      else if (stb.wrIrqClr) funcPend  <= 1'b0;
    end
  end

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hostScr[i] <= '0;
        chipScr[i] <= '0;
      end else begin
        if (stb.wrHostScr[i]) hostScr[i] <= regWdata;
        if (chipScrWe[i])     chipScr[i] <= chipScrData;
      end
    end
    assign hostScratch[i*DW +: DW] = hostScr[i];
  end

  // Internal reset overrides a host write of the same bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdEn <= '0;
      extEn <= '0;
    end else begin
      if (stb.wrStdEn) stdEn <= regWdata[FUNC_N-1:0];
      if (stb.wrExtEn) extEn <= regWdata[FUNC_N-1:0] & ~funcReset;
      else             extEn <= extEn & ~funcReset;
    end
  end

  always_comb begin
    stdPad = '0;
    extPad = '0;
    stdPad[FUNC_N-1:0] = stdEn;
    extPad[FUNC_N-1:0] = extEn;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_SLEEP: regRdata = {funcQ, 2'b00, rdyEnQ, wakeReqQ};
      SEL_IRQ:   regRdata = {6'b0, readyPend, funcPend};
      SEL_HSCR:  regRdata = hostScr[stb.scrIdx];
      SEL_CSCR:  regRdata = chipScr[stb.scrIdx];
      SEL_EXTEN: regRdata = extPad;
      SEL_STDEN: regRdata = stdPad;
      default:   regRdata = '0;
    endcase
  end

  assign sleepAllowed = ~wakeReqQ;
  assign sleepFunc    = funcQ;
  assign hostIrq      = readyPend | funcPend;
  assign resetFlag    = stdEn & ~extEn;
  assign ioActive     = stdEn & extEn;
endmodule

// File: rtl/vendor_sleep_bank.sv
module vendor_sleep_bank
  import vsb_pkg::*;
#(
  parameter int unsigned FUNC_N = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AW-1:0]       regAddr,
  input  logic [DW-1:0]       regWdata,
  input  logic                regWrite,
  output logic [DW-1:0]       regRdata,
  input  logic                isAwake,
  output logic                sleepAllowed,
  output logic [3:0]          sleepFunc,
  input  logic                funcIrqSet,
  output logic                hostIrq,
  input  logic [SCR_N-1:0]    chipScrWe,
  input  logic [DW-1:0]       chipScrData,
  output logic [SCR_N*DW-1:0] hostScratch,
  input  logic [FUNC_N-1:0]   funcReset,
  output logic [FUNC_N-1:0]   resetFlag,
  output logic [FUNC_N-1:0]   ioActive
);
  vsbStrobe_t stb;

  vsb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .wrLow    (regWdata[1:0]),
    .regWrite (regWrite),
    .isAwake  (isAwake),
    .stb      (stb)
  );

  vsb_data #(.FUNC_N(FUNC_N)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .sleepAllowed (sleepAllowed),
    .sleepFunc    (sleepFunc),
    .funcIrqSet   (funcIrqSet),
    .hostIrq      (hostIrq),
    .chipScrWe    (chipScrWe),
    .chipScrData  (chipScrData),
    .hostScratch  (hostScratch),
    .funcReset    (funcReset),
    .resetFlag    (resetFlag),
    .ioActive     (ioActive)
  );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
  parameter int unsigned FUNC_N = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        regAddr,
  input logic [7:0]        regWdata,
  input logic              regWrite,
  input logic [7:0]        regRdata,
  input logic              funcIrqSet,
  input logic              hostIrq,
  input logic              sleepAllowed,
  input logic              setReady,
  input logic [FUNC_N-1:0] funcReset,
  input logic [FUNC_N-1:0] resetFlag,
  input logic [FUNC_N-1:0] ioActive
);
  a_r3_sleep_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 8'hF0) |=> (sleepAllowed == !$past(regWdata[0])));

  a_r4_ready_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    setReady |=> hostIrq);

  a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 8'hF1 && regWdata[0] && !funcIrqSet && !setReady)
      |=> !hostIrq);

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    funcIrqSet |=> hostIrq);

  a_r10_flags_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (ioActive & resetFlag) == '0);

  a_r11_reset_drops_active: assert property (@(posedge clk) disable iff (!rstN)
    (|funcReset) |=> ((ioActive & $past(funcReset)) == '0));

  a_r12_unused_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= 8'hF7) |-> (regRdata == 8'h00));
endmodule

bind vendor_sleep_bank vsb_checker #(.FUNC_N(FUNC_N)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWdata     (regWdata),
  .regWrite     (regWrite),
  .regRdata     (regRdata),
  .funcIrqSet   (funcIrqSet),
  .hostIrq      (hostIrq),
  .sleepAllowed (sleepAllowed),
  .setReady     (stb.setReady),
  .funcReset    (funcReset),
  .resetFlag    (resetFlag),
  .ioActive     (ioActive)
);

// File: tb/vendor_sleep_bank_test.sv
`timescale 1ns/1ps
module vendor_sleep_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        regWrite = 1'b0;
  logic [7:0]  regRdata;
  logic        isAwake = 1'b0;
  logic        sleepAllowed;
  logic [3:0]  sleepFunc;
  logic        funcIrqSet = 1'b0;
  logic        hostIrq;
  logic [1:0]  chipScrWe = '0;
  logic [7:0]  chipScrData = '0;
  logic [15:0] hostScratch;
  logic [7:0]  funcReset = '0;
  logic [7:0]  resetFlag;
  logic [7:0]  ioActive;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vendor_sleep_bank uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWrite(regWrite), .regRdata(regRdata), .isAwake(isAwake),
    .sleepAllowed(sleepAllowed), .sleepFunc(sleepFunc),
    .funcIrqSet(funcIrqSet), .hostIrq(hostIrq), .chipScrWe(chipScrWe),
    .chipScrData(chipScrData), .hostScratch(hostScratch),
    .funcReset(funcReset), .resetFlag(resetFlag), .ioActive(ioActive)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    regAddr = a;
    #1;
    chk(req, {8'h00, regRdata}, {8'h00, exp});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset;
    chk("R1 sleepAllowed", sleepAllowed, 1);
    chk("R1 hostIrq", hostIrq, 0);
    chk("R1 ioActive", ioActive, 0);
    chk("R1 resetFlag", resetFlag, 0);
    chk("R1 hostScratch", hostScratch, 0);
    for (int a = 'hF0; a <= 'hF6; a++) rdChk(8'(a), 8'h00, "R1 read");
    rdChk(8'h02, 8'h00, "R1 std enable");
  endtask

  task automatic testSleepModes;
    wr(8'hF0, 8'h5F);
    rdChk(8'hF0, 8'h53, "R2 readback");
    chk("R2 sleepFunc", sleepFunc, 4'h5);
    chk("R3 awake forbids", sleepAllowed, 0);
    wr(8'hF0, 8'h00);
    chk("R3 torpid permits", sleepAllowed, 1);
    wr(8'hF0, 8'h01);
    chk("R3 awake encoding", sleepAllowed, 0);
    rdChk(8'hF0, 8'h01, "R2 awake readback");
    wr(8'hF0, 8'h02);
    chk("R3 bit0 clear permits", sleepAllowed, 1);
    wr(8'hF0, 8'h00);
  endtask

  task automatic testDrowsy;
    isAwake = 1'b0;
    wr(8'hF0, 8'h33);
    chk("R3 drowsy forbids", sleepAllowed, 0);
    idle(3);
    chk("R4 no irq while asleep", hostIrq, 0);
    @(negedge clk); isAwake = 1'b1;
    @(negedge clk);
    chk("R4 irq on wake", hostIrq, 1);
    rdChk(8'hF1, 8'h02, "R5 ready pending bit");
    wr(8'hF1, 8'h01);
    chk("R5 clear", hostIrq, 0);
    idle(3);
    chk("R4 fires once", hostIrq, 0);
    wr(8'hF0, 8'h03);
    @(negedge clk);
    chk("R4 already awake fires", hostIrq, 1);
    wr(8'hF1, 8'h01);
    isAwake = 1'b0;
    wr(8'hF0, 8'h03);
    wr(8'hF0, 8'h01);
    @(negedge clk); isAwake = 1'b1;
    idle(2);
    chk("R4 disarmed by rewrite", hostIrq, 0);
    isAwake = 1'b0;
    wr(8'hF0, 8'h00);
  endtask

  task automatic testIrqClear;
    @(negedge clk); funcIrqSet = 1'b1;
    @(negedge clk); funcIrqSet = 1'b0;
    chk("R6 func irq set", hostIrq, 1);
    rdChk(8'hF1, 8'h01, "R6 func pending bit");
    wr(8'hF1, 8'hFE);
    chk("R5 zero bit no effect", hostIrq, 1);
    wr(8'hF1, 8'h01);
    chk("R5 one clears", hostIrq, 0);
    rdChk(8'hF1, 8'h00, "R5 cleared readback");
  endtask

  task automatic testCollision;
    @(negedge clk);
    funcIrqSet = 1'b1;
    regAddr = 8'hF1; regWdata = 8'h01; regWrite = 1'b1;
    @(negedge clk);
    funcIrqSet = 1'b0; regWrite = 1'b0;
    chk("R7 func set beats clear", hostIrq, 1);
    rdChk(8'hF1, 8'h01, "R7 func pending kept");
    wr(8'hF1, 8'h01);
    wr(8'hF0, 8'h03);
    @(negedge clk);
    isAwake = 1'b1;
    regAddr = 8'hF1; regWdata = 8'h01; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
    rdChk(8'hF1, 8'h02, "R7 ready set beats clear");
    wr(8'hF1, 8'h01);
    isAwake = 1'b0;
    wr(8'hF0, 8'h00);
    chk("R7 cleared after", hostIrq, 0);
  endtask

  task automatic testScratch;
    wr(8'hF2, 8'hA5);
    wr(8'hF3, 8'h3C);
    rdChk(8'hF2, 8'hA5, "R8 scratch0");
    rdChk(8'hF3, 8'h3C, "R8 scratch1");
    chk("R8 hostScratch out", hostScratch, 16'h3CA5);
    @(negedge clk); chipScrWe = 2'b01; chipScrData = 8'h12;
    @(negedge clk); chipScrWe = 2'b10; chipScrData = 8'h34;
    @(negedge clk); chipScrWe = 2'b00;
    rdChk(8'hF4, 8'h12, "R9 chip scratch0");
    rdChk(8'hF5, 8'h34, "R9 chip scratch1");
    wr(8'hF4, 8'hFF);
    wr(8'hF5, 8'hEE);
    rdChk(8'hF4, 8'h12, "R9 host write ignored 0");
    rdChk(8'hF5, 8'h34, "R9 host write ignored 1");
  endtask

  task automatic testIoEnable;
    wr(8'h02, 8'h0E);
    chk("R10 flag before ext", resetFlag, 8'h0E);
    chk("R10 inactive before ext", ioActive, 8'h00);
    wr(8'hF6, 8'h0E);
    chk("R10 flag cleared", resetFlag, 8'h00);
    chk("R10 active", ioActive, 8'h0E);
    rdChk(8'h02, 8'h0E, "R10 std readback");
    rdChk(8'hF6, 8'h0E, "R10 ext readback");
    @(negedge clk); funcReset = 8'h04;
    @(negedge clk); funcReset = 8'h00;
    chk("R11 reset flagged", resetFlag, 8'h04);
    chk("R11 active dropped", ioActive, 8'h0A);
    rdChk(8'hF6, 8'h0A, "R11 ext bit cleared");
    wr(8'hF6, 8'h0E);
    chk("R10 re-enable", resetFlag, 8'h00);
    @(negedge clk);
    funcReset = 8'h08;
    regAddr = 8'hF6; regWdata = 8'h0E; regWrite = 1'b1;
    @(negedge clk);
    funcReset = 8'h00; regWrite = 1'b0;
    rdChk(8'hF6, 8'h06, "R11 reset beats write");
    chk("R11 flag on collision", resetFlag, 8'h08);
  endtask

  task automatic testUnused;
    wr(8'hF8, 8'hAA);
    wr(8'hFF, 8'h55);
    wr(8'h40, 8'h77);
    for (int a = 'hF7; a <= 'hFF; a++) rdChk(8'(a), 8'h00, "R12 unused read");
    rdChk(8'h40, 8'h00, "R12 low unused read");
    rdChk(8'hF2, 8'hA5, "R12 scratch untouched");
    rdChk(8'hF0, 8'h00, "R12 sleep untouched");
    chk("R12 hostScratch untouched", hostScratch, 16'h3CA5);
    chk("R12 no irq", hostIrq, 0);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset;
    testSleepModes;
    testDrowsy;
    testIrqClear;
    testCollision;
    testScratch;
    testIoEnable;
    testUnused;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule